// File: doc/BRIEF.md
# Serial Debug Command Port

This block is the serial front end of an on-chip debug controller. An external host toggles a serial clock and a serial data line. Each transaction opens with an 8-bit command, most significant bit first. The top bit of the command sets the direction. For a write, 32 data bits follow and are collected into a data register. For a read, the block waits for the core to supply a word, then returns that word on the serial output, most significant bit first. The serial clock, the serial data and the external debug request all pass through two-flop synchronizers into the system clock. Serial falling edges are detected in that domain, so the host clock must stay well below the system clock: each serial clock level must last at least three system cycles.

One active-low output line carries three things: the read data bits, a two-cycle low "data ready" pulse, and a one-cycle low acknowledge when the core reports that it has entered debug mode. That acknowledge also clears the bit counter and returns the port to command reception. Command completion and data-word completion are exported as single-cycle strobes for the decoder that follows.

Top module: `dbgser_port`

## Requirements
- R1: While reset is asserted and right after it is released, ser_out is high, cmd_strobe and data_strobe are low, and core_dbg_req is low.
- R2: In the command phase, each synchronized falling edge of sck shifts sdi into the command register MSB first. On the eighth bit, cmd_word holds the full command and cmd_strobe is high for exactly one clk cycle.
- R3: After the eighth command bit, cmd_word stops shifting and holds its value through the data phase that follows.
- R4: A command with bit 7 equal to 0 is a write. The next 32 falling edges shift sdi MSB first into wr_data, and data_strobe is high for one clk cycle on the 32nd edge.
- R5: A command with bit 7 equal to 1 is a read. ser_out stays high until rd_ready is seen. The rd_ready cycle loads rd_data and drives ser_out low for exactly two clk cycles, after which ser_out shows bit 31.
- R6: During a read, each falling edge moves ser_out to the next lower bit. After the 32nd edge, data_strobe pulses for one cycle, ser_out returns high and the port awaits a new command.
- R7: A core_ack pulse drives ser_out low for exactly one clk cycle, starting in the cycle after core_ack.
- R8: core_ack clears the bit counter and returns the port to the command phase, aborting any partial command, write or read. If core_ack coincides with a detected falling edge, core_ack wins and that bit is discarded.
- R9: rd_ready outside the read-wait phase has no effect: ser_out stays high and no word is loaded.
- R10: dbg_req_in reaches core_dbg_req through two clk flops, so core_dbg_req follows it two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Host serial clock, idles low |
| sdi | input | 1 | Host serial data in |
| dbg_req_in | input | 1 | External debug request (asynchronous) |
| core_ack | input | 1 | Core strobe: debug mode entered |
| rd_ready | input | 1 | Core strobe: read word valid |
| rd_data | input | 32 | Read word from the core |
| ser_out | output | 1 | Serial out: read data, or low pulses for ready and acknowledge |
| core_dbg_req | output | 1 | Synchronized debug request to the core |
| cmd_strobe | output | 1 | One-cycle strobe: command complete |
| cmd_word | output | 8 | Last received command |
| data_strobe | output | 1 | One-cycle strobe: 32 data bits in or out |
| wr_data | output | 32 | Collected write word |

## Verification
The acknowledge from the core and a serial falling edge can land in the same clk cycle. One path clears the bit counter and the other advances it. The bench sets this up by lowering sck and asserting core_ack exactly two edges later, so both reach the state register on the same edge. This is done five bits into a command. It then sends a full fresh command and checks that cmd_word matches it exactly: if the discarded bit had been counted, the word would be misaligned by one bit. A second overlap sets the acknowledge against a read in progress, and expects a single low cycle followed by the idle level.

// File: rtl/dbgser_pkg.sv
package dbgser_pkg;

  typedef enum logic [1:0] {
    PH_CMD   = 2'd0,
    PH_WR    = 2'd1,
    PH_RWAIT = 2'd2,
    PH_RD    = 2'd3
  } phase_t;

  // true when the bit about to be counted is the last one of a field
  function automatic logic at_last(int unsigned cnt, int unsigned len);
    return (cnt + 1) == len;
  endfunction

  // direction bit of a completed command: 1 = read, 0 = write
  function automatic logic cmd_is_read(logic msb);
    return msb;
  endfunction

endpackage

// File: rtl/dbgser_sync.sv
module dbgser_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1[g] <= 1'b0;
        stage2[g] <= 1'b0;
      end else begin
        stage1[g] <= d_async[g];
        stage2[g] <= stage1[g];
      end
    end
  end

  assign d_sync = stage2;
endmodule

// File: rtl/dbgser_pulse.sv
module dbgser_pulse #(
  parameter int LEN = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic clear,
  output logic active
);
  localparam int LW = $clog2(LEN + 1);

  logic [LW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (clear)          left_q <= '0;
    else if (start)          left_q <= LW'(LEN);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign active = (left_q != '0);

  // R5, R7: a started pulse is visible in the next cycle
  p_pulse_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !clear) |=> active);

  // R5, R7: a running pulse never grows unless restarted
  p_pulse_shrink_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start && !clear) |=> (left_q < $past(left_q)));
endmodule

// File: rtl/dbgser_shift.sv
module dbgser_shift
  import dbgser_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              sdi_s,
  input  logic              ack,
  input  logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              hold,
  output phase_t            phase,
  output logic              load_evt,
  output logic              rd_bit,
  output logic [CMD_W-1:0]  cmd_word,
  output logic              cmd_strobe,
  output logic [DATA_W-1:0] wr_data,
  output logic              data_strobe
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [CNT_W-1:0]  bit_cnt;
  logic [CMD_W-1:0]  cmd_sr;
  logic [DATA_W-1:0] wr_sr;
  logic [DATA_W-1:0] rd_sr;
  logic              cmd_done;
  logic              word_done;
  logic              rd_step;

  assign load_evt  = (phase == PH_RWAIT) && rd_ready && !ack;
  assign rd_step   = (phase == PH_RD) && fall && !hold && !ack;
  assign cmd_done  = (phase == PH_CMD) && fall && !ack && at_last(int'(bit_cnt), CMD_W);
  assign word_done = ((phase == PH_WR && fall && !ack) || rd_step)
                     && at_last(int'(bit_cnt), DATA_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_CMD;
      bit_cnt     <= '0;
      cmd_sr      <= '0;
      wr_sr       <= '0;
      rd_sr       <= '0;
      cmd_strobe  <= 1'b0;
      data_strobe <= 1'b0;
    end else begin
      cmd_strobe  <= cmd_done;
      data_strobe <= word_done;
      if (ack) begin
        phase   <= PH_CMD;
        bit_cnt <= '0;
      end else begin
        unique case (phase)
          PH_CMD: if (fall) begin
            cmd_sr <= {cmd_sr[CMD_W-2:0], sdi_s};
            if (cmd_done) begin
              bit_cnt <= '0;
              phase   <= cmd_is_read(cmd_sr[CMD_W-2]) ? PH_RWAIT : PH_WR;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          PH_WR: if (fall) begin
            wr_sr <= {wr_sr[DATA_W-2:0], sdi_s};
            if (word_done) begin
              bit_cnt <= '0;
              phase   <= PH_CMD;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          PH_RWAIT: if (rd_ready) begin
            rd_sr <= rd_data;
            phase <= PH_RD;
          end
          PH_RD: if (rd_step) begin
            rd_sr <= {rd_sr[DATA_W-2:0], 1'b0};
            if (word_done) begin
              bit_cnt <= '0;
              phase   <= PH_CMD;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          default: phase <= PH_CMD;
        endcase
      end
    end
  end

  assign cmd_word = cmd_sr;
  assign wr_data  = wr_sr;
  assign rd_bit   = rd_sr[DATA_W-1];

  // R2: the counter never passes the command length in the command phase
  p_cnt_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CMD) |-> (int'(bit_cnt) < CMD_W));

  // R2: command strobe lasts one cycle
  p_cmd_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |=> !cmd_strobe);

  // R3: the command register is frozen outside the command phase
  p_cmd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_CMD) |=> $stable(cmd_word));

  // R8: acknowledge clears the counter and returns to command reception
  p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (bit_cnt == '0 && phase == PH_CMD));
endmodule

// File: rtl/dbgser_port.sv
module dbgser_port
  import dbgser_pkg::*;
#(
  parameter int CMD_W   = 8,
  parameter int DATA_W  = 32,
  parameter int RDY_LOW = 2,
  parameter int ACK_LOW = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              dbg_req_in,
  input  logic              core_ack,
  input  logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic              ser_out,
  output logic              core_dbg_req,
  output logic              cmd_strobe,
  output logic [CMD_W-1:0]  cmd_word,
  output logic              data_strobe,
  output logic [DATA_W-1:0] wr_data
);
  logic [2:0] sync_out;
  logic       sck_s;
  logic       sdi_s;
  logic       sck_prev;
  logic       fall;
  logic       ack_act;
  logic       rdy_act;
  logic       load_evt;
  logic       rd_bit;
  phase_t     phase;

  dbgser_sync #(.W(3)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({dbg_req_in, sdi, sck}),
    .d_sync  (sync_out)
  );

  assign sck_s        = sync_out[0];
  assign sdi_s        = sync_out[1];
  assign core_dbg_req = sync_out[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= sck_s;
  end

  assign fall = sck_prev && !sck_s;

  dbgser_shift #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .fall        (fall),
    .sdi_s       (sdi_s),
    .ack         (core_ack),
    .rd_ready    (rd_ready),
    .rd_data     (rd_data),
    .hold        (rdy_act),
    .phase       (phase),
    .load_evt    (load_evt),
    .rd_bit      (rd_bit),
    .cmd_word    (cmd_word),
    .cmd_strobe  (cmd_strobe),
    .wr_data     (wr_data),
    .data_strobe (data_strobe)
  );

  dbgser_pulse #(.LEN(ACK_LOW)) u_ack_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (core_ack),
    .clear  (1'b0),
    .active (ack_act)
  );

  dbgser_pulse #(.LEN(RDY_LOW)) u_rdy_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (load_evt),
    .clear  (core_ack),
    .active (rdy_act)
  );

  assign ser_out = !(ack_act || rdy_act) && ((phase == PH_RD) ? rd_bit : 1'b1);

  // R7: acknowledge shows as a low level in the following cycle
  p_ack_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    core_ack |=> !ser_out);

  // R5: loading a read word pulls the line low in the following cycle
  p_load_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !ser_out);

  // R4, R6: command and data completion never coincide
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_strobe && data_strobe));
endmodule

// File: tb/dbgser_port_bench.sv
module dbgser_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 6;
  localparam int WD_LIMIT   = 150000;

  // {command[7:0], data[31:0]}; bit 7 of the command set means read
  localparam logic [39:0] VECS [0:NVEC-1] = '{
    {8'h15, 32'hA5F0_0F5A},
    {8'h93, 32'hDEAD_BEEF},
    {8'h00, 32'h8000_0001},
    {8'hFF, 32'h8123_4567},
    {8'h7F, 32'hFFFF_FFFF},
    {8'hC4, 32'hF0F0_1234}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0;
  logic        sdi = 1'b0;
  logic        dbg_req_in = 1'b0;
  logic        core_ack = 1'b0;
  logic        rd_ready = 1'b0;
  logic [31:0] rd_data = '0;
  logic        ser_out;
  logic        core_dbg_req;
  logic        cmd_strobe;
  logic [7:0]  cmd_word;
  logic        data_strobe;
  logic [31:0] wr_data;

  int checks = 0;
  int fails  = 0;
  int cmd_cnt = 0;
  int data_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbgser_port u_dbgser_port (
    .clk          (clk),
    .rst_n        (rst_n),
    .sck          (sck),
    .sdi          (sdi),
    .dbg_req_in   (dbg_req_in),
    .core_ack     (core_ack),
    .rd_ready     (rd_ready),
    .rd_data      (rd_data),
    .ser_out      (ser_out),
    .core_dbg_req (core_dbg_req),
    .cmd_strobe   (cmd_strobe),
    .cmd_word     (cmd_word),
    .data_strobe  (data_strobe),
    .wr_data      (wr_data)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_strobe)  cmd_cnt++;
      if (data_strobe) data_cnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdi = b;
    sck = 1'b1;
    tick(4);
    sck = 1'b0;
    tick(4);
  endtask

  task automatic send_cmd(input logic [7:0] c);
    for (int i = 7; i >= 0; i--) send_bit(c[i]);
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_ack;
    core_ack = 1'b1;
    tick(1);
    core_ack = 1'b0;
  endtask

  // read out one word: returns the 32 observed bits
  task automatic read_word(output logic [31:0] got);
    for (int i = 31; i >= 0; i--) begin
      got[i] = ser_out;
      sck = 1'b1;
      tick(4);
      sck = 1'b0;
      tick(4);
    end
  endtask

  task automatic give_ready(input logic [31:0] w);
    rd_data  = w;
    rd_ready = 1'b1;
    tick(1);
    rd_ready = 1'b0;
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", WD_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int c0;
    int d0;
    logic [31:0] got;
    logic [7:0]  cmd;
    logic [31:0] dat;

    // R1: reset state
    tick(3);
    chk("R1 ser_out in reset", 32'(ser_out), 32'd1);
    rst_n = 1'b1;
    tick(3);
    chk("R1 ser_out after reset", 32'(ser_out), 32'd1);
    chk("R1 strobes after reset", {30'd0, cmd_strobe, data_strobe}, 32'd0);
    chk("R1 core_dbg_req after reset", 32'(core_dbg_req), 32'd0);

    // R10: two-flop request path
    dbg_req_in = 1'b1;
    tick(1);
    chk("R10 req after one edge", 32'(core_dbg_req), 32'd0);
    tick(1);
    chk("R10 req after two edges", 32'(core_dbg_req), 32'd1);
    dbg_req_in = 1'b0;
    tick(2);
    chk("R10 req released", 32'(core_dbg_req), 32'd0);

    // table of transactions
    for (int v = 0; v < NVEC; v++) begin
      cmd = VECS[v][39:32];
      dat = VECS[v][31:0];
      c0 = cmd_cnt;
      d0 = data_cnt;
      send_cmd(cmd);
      chk("R2 cmd_word", 32'(cmd_word), 32'(cmd));
      chk("R2 one cmd_strobe", 32'(cmd_cnt - c0), 32'd1);
      if (!cmd[7]) begin
        send_word(dat);
        chk("R4 wr_data", wr_data, dat);
        chk("R4 one data_strobe", 32'(data_cnt - d0), 32'd1);
        chk("R3 cmd_word held", 32'(cmd_word), 32'(cmd));
      end else begin
        tick(6);
        chk("R5 line high while waiting", 32'(ser_out), 32'd1);
        chk("R5 before ready", 32'(ser_out), 32'd1);
        give_ready(dat);
        chk("R5 ready low cycle 1", 32'(ser_out), 32'd0);
        tick(1);
        chk("R5 ready low cycle 2", 32'(ser_out), 32'd0);
        tick(1);
        chk("R5 msb after pulse", 32'(ser_out), 32'(dat[31]));
        tick(2);
        read_word(got);
        chk("R6 read bits", got, dat);
        chk("R6 one data_strobe", 32'(data_cnt - d0), 32'd1);
        chk("R6 line idle after read", 32'(ser_out), 32'd1);
        chk("R3 cmd_word held", 32'(cmd_word), 32'(cmd));
      end
    end

    // R7: acknowledge pulse width
    chk("R7 high before ack", 32'(ser_out), 32'd1);
    pulse_ack();
    chk("R7 low one cycle", 32'(ser_out), 32'd0);
    tick(1);
    chk("R7 high after one cycle", 32'(ser_out), 32'd1);

    // R8: ack mid-command discards partial bits
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    pulse_ack();
    tick(2);
    c0 = cmd_cnt;
    send_cmd(8'h2A);
    chk("R8 cmd after abort", 32'(cmd_word), 32'h2A);
    chk("R8 one strobe after abort", 32'(cmd_cnt - c0), 32'd1);
    send_word(32'h1357_9BDF);
    chk("R8 write after abort", wr_data, 32'h1357_9BDF);

    // R8: ack coinciding with a detected falling edge
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    sdi = 1'b1;
    sck = 1'b1;
    tick(4);
    sck = 1'b0;
    tick(2);
    core_ack = 1'b1;
    tick(1);
    core_ack = 1'b0;
    tick(4);
    c0 = cmd_cnt;
    send_cmd(8'h3C);
    chk("R8 coincident edge discarded", 32'(cmd_word), 32'h3C);
    chk("R8 coincident one strobe", 32'(cmd_cnt - c0), 32'd1);
    send_word(32'h0F0F_A5A5);
    chk("R8 write after coincidence", wr_data, 32'h0F0F_A5A5);

    // R8: ack aborts a read in progress
    send_cmd(8'hA0);
    give_ready(32'hFFFF_0000);
    tick(3);
    for (int i = 0; i < 5; i++) begin
      sck = 1'b1; tick(4); sck = 1'b0; tick(4);
    end
    pulse_ack();
    chk("R8 ack low during read", 32'(ser_out), 32'd0);
    tick(1);
    chk("R8 line idle after read abort", 32'(ser_out), 32'd1);
    send_cmd(8'h11);
    send_word(32'hCAFE_0001);
    chk("R8 write after read abort", wr_data, 32'hCAFE_0001);

    // R9: ready outside the wait phase is ignored
    give_ready(32'h0000_0000);
    chk("R9 no pulse in command phase", 32'(ser_out), 32'd1);
    tick(1);
    chk("R9 still high", 32'(ser_out), 32'd1);
    send_cmd(8'h81);
    tick(6);
    chk("R9 read waits for fresh ready", 32'(ser_out), 32'd1);
    give_ready(32'hB000_00F1);
    tick(3);
    read_word(got);
    chk("R9 fresh word read", got, 32'hB000_00F1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule